// File: doc/BRIEF.md
# I2C Slave Address Match Unit

This block decides, once per transfer, whether the calling address that follows a START condition belongs to this device. The bus engine shifts in the first byte after a START or repeated START and hands it over with a single-cycle valid strobe. The matcher compares the upper seven bits of that byte against five candidate sources. Any source that agrees produces one match pulse on the next clock. That pulse lands well inside the ninth bit period, so the engine can still decide whether to drive ACK.

The five sources are the primary address, the range register taken as a plain address, the general call code, a second programmable address, and the SMBus alert response code. The primary source is always active. The range register acts as a plain address only while it holds a nonzero value. Each of the other three sources has its own enable. When range matching is enabled, any address lying strictly above the primary address and strictly below the range register also matches, and that case raises a separate range flag. The read/write bit of a matching byte is captured and held for the slave direction flag.

Top module: `i2c_addr_match`

## Requirements
- R1: When the calling address (addr_byte[7:1]) equals prim_addr, match_o is high for exactly the one cycle after the byte_valid cycle.
- R2: A calling address equal to rng_addr matches only while rng_addr is nonzero. An address of 0 with rng_addr zero and gc_en low gives no match.
- R3: A calling address of 7'h00 matches when gc_en is high and does not match through this source when gc_en is low.
- R4: A calling address equal to sec_addr matches only while sec_en is high.
- R5: A calling address of 7'b0001100 (7'h0C) matches only while alert_en is high.
- R6: With rng_en high, a calling address with prim_addr < address < rng_addr matches and sets range_o. Addresses equal to either bound leave range_o low. With rng_en low, such an in-between address does not match.
- R7: On a match, rw_o takes addr_byte[0]. When a byte does not match, rw_o keeps its previous value.
- R8: Only the first byte_valid after a bus_start pulse is evaluated. Later bytes give no match until the next bus_start.
- R9: After reset, match_o, range_o and rw_o are all 0.
- R10: range_o is updated on every evaluated byte and holds between evaluated bytes. A byte that does not match gives no match_o pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Pulse on START or repeated START |
| byte_valid | input | 1 | Strobe: a received byte is on addr_byte |
| addr_byte | input | 8 | Received byte; [7:1] address, [0] R/W |
| prim_addr | input | 7 | Primary own address |
| sec_addr | input | 7 | Second own address |
| rng_addr | input | 7 | Range register (upper bound, also direct address when nonzero) |
| gc_en | input | 1 | Enable general call match |
| sec_en | input | 1 | Enable second address match |
| alert_en | input | 1 | Enable alert response match |
| rng_en | input | 1 | Enable range match |
| match_o | output | 1 | One-cycle match pulse |
| range_o | output | 1 | Last evaluated address was inside the range |
| rw_o | output | 1 | Captured R/W bit of the last match |

## Verification
Each source is tried once with its enable set and once with it cleared, using the same calling address. This shows that the enable really gates that comparator and that no other source covers for it. For the range source, addresses inside the range are compared with the two bound values and with a value just above the upper bound. This shows where the strict comparison ends and the direct matches take over. Repeated bytes with no START between them show that only the address byte is evaluated. Alternating R/W bits on matching and non-matching bytes show that the flag is captured only on a match.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int SRC_CNT = 5;
  typedef enum int {
    SRC_PRIM  = 0,
    SRC_RNGEQ = 1,
    SRC_GCALL = 2,
    SRC_SEC   = 3,
    SRC_ALERT = 4
  } src_e;
  localparam logic [6:0] GCALL_CODE = 7'h00;
  localparam logic [6:0] ALERT_CODE = 7'h0C;
endpackage

// File: rtl/i2cam_frame_track.sv
module i2cam_frame_track (
  input  logic clk,
  input  logic rst,
  input  logic bus_start,
  input  logic byte_valid,
  output logic armed,
  output logic eval
);
  always_ff @(posedge clk) begin
    if (rst)             armed <= 1'b0;
    else if (bus_start)  armed <= 1'b1;
    else if (byte_valid) armed <= 1'b0;
  end

  assign eval = byte_valid & armed;
endmodule

// File: rtl/i2cam_direct_cmp.sv
module i2cam_direct_cmp #(
  parameter int AW = 7,
  parameter int N  = 5
) (
  input  logic [AW-1:0]         addr,
  input  logic [N-1:0][AW-1:0]  refs,
  input  logic [N-1:0]          en,
  output logic [N-1:0]          hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = en[i] & (addr == refs[i]);
  end
endmodule

// File: rtl/i2cam_range_cmp.sv
module i2cam_range_cmp #(
  parameter int AW = 7
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic          en,
  output logic          hit
);
  assign hit = en & (addr > lo) & (addr < hi);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_start,
  input  logic          byte_valid,
  input  logic [AW:0]   addr_byte,
  input  logic [AW-1:0] prim_addr,
  input  logic [AW-1:0] sec_addr,
  input  logic [AW-1:0] rng_addr,
  input  logic          gc_en,
  input  logic          sec_en,
  input  logic          alert_en,
  input  logic          rng_en,
  output logic          match_o,
  output logic          range_o,
  output logic          rw_o
);
  logic                       armed;
  logic                       eval;
  logic [AW-1:0]              calling;
  logic [SRC_CNT-1:0][AW-1:0] refs;
  logic [SRC_CNT-1:0]         src_en;
  logic [SRC_CNT-1:0]         src_hit;
  logic                       rng_hit;
  logic                       any_hit;

  assign calling = addr_byte[AW:1];

  always_comb begin
    refs              = '0;
    src_en            = '0;
    refs[SRC_PRIM]    = prim_addr;
    src_en[SRC_PRIM]  = 1'b1;
    refs[SRC_RNGEQ]   = rng_addr;
    src_en[SRC_RNGEQ] = (rng_addr != '0);
    refs[SRC_GCALL]   = AW'(GCALL_CODE);
    src_en[SRC_GCALL] = gc_en;
    refs[SRC_SEC]     = sec_addr;
    src_en[SRC_SEC]   = sec_en;
    refs[SRC_ALERT]   = AW'(ALERT_CODE);
    src_en[SRC_ALERT] = alert_en;
  end

  i2cam_frame_track u_trk (
    .clk(clk), .rst(rst), .bus_start(bus_start),
    .byte_valid(byte_valid), .armed(armed), .eval(eval)
  );

  i2cam_direct_cmp #(.AW(AW), .N(SRC_CNT)) u_dir (
    .addr(calling), .refs(refs), .en(src_en), .hit(src_hit)
  );

  i2cam_range_cmp #(.AW(AW)) u_rng (
    .addr(calling), .lo(prim_addr), .hi(rng_addr), .en(rng_en), .hit(rng_hit)
  );

  assign any_hit = (|src_hit) | rng_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      match_o <= 1'b0;
      range_o <= 1'b0;
      rw_o    <= 1'b0;
    end else begin
      match_o <= eval & any_hit;
      if (eval) begin
        range_o <= rng_hit;
        if (any_hit) rw_o <= addr_byte[0];
      end
    end
  end
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          byte_valid,
  input logic          armed,
  input logic [AW-1:0] calling,
  input logic [AW-1:0] prim_addr,
  input logic          gc_en,
  input logic          match_o,
  input logic          range_o,
  input logic          rw_o
);
  assert_prim_R1: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && armed && calling == prim_addr) |=> match_o);

  assert_gcall_R3: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && armed && gc_en && calling == '0) |=> match_o);

  assert_range_has_match_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(range_o) |-> match_o);

  assert_rw_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !match_o |-> $stable(rw_o));

  assert_only_addr_byte_R8: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && !armed) |=> !match_o);

  assert_range_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(byte_valid) |-> $stable(range_o));
endmodule

bind i2c_addr_match i2c_addr_match_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .byte_valid(byte_valid), .armed(armed),
  .calling(calling), .prim_addr(prim_addr), .gc_en(gc_en),
  .match_o(match_o), .range_o(range_o), .rw_o(rw_o)
);

// File: tb/tb_i2c_addr_match.sv
module tb_i2c_addr_match;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_start = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] addr_byte = '0;
  logic [6:0] prim_addr = 7'h3A;
  logic [6:0] sec_addr = 7'h21;
  logic [6:0] rng_addr = 7'h00;
  logic       gc_en = 1'b0, sec_en = 1'b0, alert_en = 1'b0, rng_en = 1'b0;
  logic       match_o, range_o, rw_o;

  int n_chk = 0;
  int n_bad = 0;
  logic exp_rw = 1'b0;

  always #2 clk = ~clk;

  i2c_addr_match dut (
    .clk(clk), .rst(rst), .bus_start(bus_start), .byte_valid(byte_valid),
    .addr_byte(addr_byte), .prim_addr(prim_addr), .sec_addr(sec_addr),
    .rng_addr(rng_addr), .gc_en(gc_en), .sec_en(sec_en), .alert_en(alert_en),
    .rng_en(rng_en), .match_o(match_o), .range_o(range_o), .rw_o(rw_o)
  );

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b, input logic with_start);
    @(negedge clk);
    if (with_start) begin
      bus_start = 1'b1;
      @(negedge clk);
      bus_start = 1'b0;
    end
    addr_byte  = b;
    byte_valid = 1'b1;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic try_addr(input string req, input logic [6:0] a, input logic rw,
                          input logic exp_m, input logic exp_r, input logic with_start);
    put_byte({a, rw}, with_start);
    if (exp_m) exp_rw = rw;
    chk(req, match_o, exp_m, "match_o");
    chk(req, range_o, exp_r, "range_o");
    chk(req, rw_o, exp_rw, "rw_o");
    @(negedge clk);
    chk(req, match_o, 1'b0, "match_o pulse end");
  endtask

  task automatic t_reset;
    chk("R9", match_o, 1'b0, "match_o after reset");
    chk("R9", range_o, 1'b0, "range_o after reset");
    chk("R9", rw_o, 1'b0, "rw_o after reset");
  endtask

  task automatic t_primary;
    try_addr("R1", 7'h3A, 1'b1, 1'b1, 1'b0, 1'b1);
    try_addr("R10", 7'h3B, 1'b0, 1'b0, 1'b0, 1'b1);
    try_addr("R7", 7'h3A, 1'b0, 1'b1, 1'b0, 1'b1);
    try_addr("R7", 7'h11, 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_rng_direct;
    rng_addr = 7'h00;
    try_addr("R2", 7'h00, 1'b1, 1'b0, 1'b0, 1'b1);
    rng_addr = 7'h50;
    try_addr("R2", 7'h50, 1'b1, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_gcall;
    rng_addr = 7'h00;
    gc_en = 1'b1;
    try_addr("R3", 7'h00, 1'b0, 1'b1, 1'b0, 1'b1);
    gc_en = 1'b0;
    try_addr("R3", 7'h00, 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_second;
    sec_en = 1'b0;
    try_addr("R4", 7'h21, 1'b1, 1'b0, 1'b0, 1'b1);
    sec_en = 1'b1;
    try_addr("R4", 7'h21, 1'b1, 1'b1, 1'b0, 1'b1);
    sec_en = 1'b0;
  endtask

  task automatic t_alert;
    try_addr("R5", 7'h0C, 1'b0, 1'b0, 1'b0, 1'b1);
    alert_en = 1'b1;
    try_addr("R5", 7'h0C, 1'b0, 1'b1, 1'b0, 1'b1);
    alert_en = 1'b0;
  endtask

  task automatic t_range;
    rng_addr = 7'h50;
    rng_en = 1'b1;
    try_addr("R6", 7'h40, 1'b1, 1'b1, 1'b1, 1'b1);
    try_addr("R6", 7'h3B, 1'b0, 1'b1, 1'b1, 1'b1);
    try_addr("R6", 7'h3A, 1'b1, 1'b1, 1'b0, 1'b1);
    try_addr("R6", 7'h4F, 1'b0, 1'b1, 1'b1, 1'b1);
    try_addr("R6", 7'h50, 1'b1, 1'b1, 1'b0, 1'b1);
    try_addr("R6", 7'h45, 1'b0, 1'b1, 1'b1, 1'b1);
    try_addr("R10", 7'h51, 1'b1, 1'b0, 1'b0, 1'b1);
    rng_en = 1'b0;
    try_addr("R6", 7'h40, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_first_only;
    rng_addr = 7'h00;
    try_addr("R8", 7'h3A, 1'b1, 1'b1, 1'b0, 1'b1);
    try_addr("R8", 7'h3A, 1'b0, 1'b0, 1'b0, 1'b0);
    try_addr("R8", 7'h3A, 1'b0, 1'b0, 1'b0, 1'b0);
    try_addr("R8", 7'h3A, 1'b0, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_range_hold;
    rng_addr = 7'h50;
    rng_en = 1'b1;
    try_addr("R10", 7'h44, 1'b1, 1'b1, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    chk("R10", range_o, 1'b1, "range_o held");
    try_addr("R10", 7'h44, 1'b0, 1'b0, 1'b1, 1'b0);
    try_addr("R10", 7'h3A, 1'b0, 1'b1, 1'b0, 1'b1);
    rng_en = 1'b0;
  endtask

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_primary();
    t_rng_direct();
    t_gcall();
    t_second();
    t_alert();
    t_range();
    t_first_only();
    t_range_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule